// File: doc/BRIEF.md
# Averaging Multi-Channel ADC Sequencer

This block is a register-controlled sequencer for an external successive-approximation converter with up to ten multiplexed inputs. Software chooses an input, an averaging exponent n, a conversion rate, an evaluation time and an output format in a configuration word. It then writes the start bit. The block runs 2^n conversions on that input. For each conversion it drives the multiplexer select, waits out the evaluation time and pulses a convert strobe. It then waits for the converter to hand back a 12-bit result on a sample/valid pair.

The results are summed in hardware. When the last one arrives, the sum divided by 2^n is written to the data register. The completion flag is raised, and an interrupt follows if it is enabled. A soft-reset code in the first control word abandons a running sequence and clears the result state. The configuration stays as written.

Top module: `adc_avg_seq`

## Requirements
- R1: The word at offset 0x20 always reads 0x80000008. The words at 0x18 and 0x1C read 0.
- R2: After reset, these all read 0: the status word (0x08), the data word (0x0C), the configuration word (0x04) and the interrupt status (0x14). After reset, irq and convStrobe are low.
- R3: Writing 1 to bit 0 of the control word (0x00) while idle starts a sequence on the channel in configuration bits [3:0]. muxSel then shows that channel for the whole sequence. Bit 0 of 0x00 reads back as 0.
- R4: A sequence runs 2^n conversions, where n is configuration bits [6:4]. Each conversion waits an evaluation time and then drives convStrobe high for one cycle. The evaluation time is EVAL_SHORT cycles when bit 9 is 1 and EVAL_LONG cycles when bit 9 is 0. Between conversions there is an idle gap of GAP_FAST cycles when bit 8 is 1 and GAP_SLOW cycles when bit 8 is 0.
- R5: At completion, data bits [11:0] hold floor(sum / 2^n) as straight binary when configuration bit 10 is 1. When bit 10 is 0, the same value is shown with bit 11 inverted (two's complement). Data bits [31:12] read 0.
- R6: Status bit 2 goes to 1 when a sequence completes. It clears on the next accepted start or on a read of the data word.
- R7: A start written while a sequence is running is ignored. A configuration write made during a run does not alter the running sequence.
- R8: A start with a configuration channel above 9 does not begin a sequence.
- R9: If interrupt enable bit 0 (0x10) is 1 at completion, interrupt status bit 0 (0x14) is set. irq is the AND of the two bits. Writing 1 to interrupt status bit 0 clears it.
- R10: Writing 2'b10 to control bits [2:1] aborts any sequence and clears the status flag, the data word and the interrupt status. The configuration and interrupt enable are kept.
- R11: A sampleValid that arrives while the block is not waiting for a result is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (used for read side effects) |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| muxSel | output | 4 | Analog multiplexer select |
| convStrobe | output | 1 | One-cycle convert request to the converter |
| sampleValid | input | 1 | Converter result valid |
| sampleData | input | 12 | Converter raw result |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with EVAL_SHORT=3, EVAL_LONG=5, GAP_FAST=1 and GAP_SLOW=4. These short waits let every timing-mode combination run, including a full 128-conversion average, in a few thousand cycles. With them, a per-clock model can track strobe placement exactly through evaluation and gap phases. The converter latency is varied from 1 to 3 cycles. This puts result arrival at different offsets within the waiting phase. It also lets stray valid pulses be injected during idle and evaluation.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  localparam int DATA_W = 12;
  localparam int CH_W   = 4;
  localparam int EXP_W  = 3;
  localparam int CFG_W  = 11;

  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_DATA  = 'h0C;
  localparam int OFS_IEN   = 'h10;
  localparam int OFS_IST   = 'h14;
  localparam int OFS_IDENT = 'h20;

  localparam logic [31:0] IDENT_VALUE = 32'h8000_0008;
  localparam logic [CFG_W-1:0] CFG_MASK = 11'h77F;
  localparam int DONE_BIT = 2;

  // configuration field positions
  localparam int CFG_EXP_LO = 4;
  localparam int CFG_RATE   = 8;
  localparam int CFG_EVAL   = 9;
  localparam int CFG_FMT    = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_CONV, ST_WAIT, ST_GAP
  } seqState_t;

  typedef struct packed {
    logic clrAcc;
    logic addSample;
    logic publish;
    logic clrData;
  } dpCtl_t;
endpackage

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int MAX_CH     = 9,
  parameter int EVAL_SHORT = 20,
  parameter int EVAL_LONG  = 40,
  parameter int GAP_FAST   = 4,
  parameter int GAP_SLOW   = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              sampleValid,
  output dpCtl_t            dpCtl,
  output logic [EXP_W-1:0]  actExp,
  output logic              actFmtBin,
  output logic [CH_W-1:0]   muxSel,
  output logic              convStrobe,
  output logic [CFG_W-1:0]  cfgReg,
  output logic              endFlag,
  output logic              ienBit,
  output logic              istBit,
  output logic              irq
);
  localparam int MW1 = (EVAL_LONG > EVAL_SHORT) ? EVAL_LONG : EVAL_SHORT;
  localparam int MW2 = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
  localparam int MAX_WAIT = (MW1 > MW2) ? MW1 : MW2;
  localparam int CNT_W  = $clog2(MAX_WAIT + 1);
  localparam int CONV_W = 1 << EXP_W;
  localparam logic [CNT_W-1:0] EVS_M1 = CNT_W'(EVAL_SHORT - 1);
  localparam logic [CNT_W-1:0] EVL_M1 = CNT_W'(EVAL_LONG - 1);
  localparam logic [CNT_W-1:0] GPF_M1 = CNT_W'(GAP_FAST - 1);
  localparam logic [CNT_W-1:0] GPS_M1 = CNT_W'(GAP_SLOW - 1);

  seqState_t          state;
  logic [CNT_W-1:0]   waitCnt;
  logic [CONV_W-1:0]  convCnt;
  logic [CONV_W-1:0]  lastIdx;
  logic               actEvalShort, actRateFast;
  logic               wrCtrl, softRst, idle, chanOk, startGo;
  logic               sampleTake, lastConv, finish, rdData, istClr;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata[31:CFG_W];

  assign wrCtrl     = busWr && (busAddr == ADDR_W'(OFS_CTRL));
  assign softRst    = wrCtrl && (busWdata[2:1] == 2'b10);
  assign idle       = (state == ST_IDLE);
  assign chanOk     = (cfgReg[CH_W-1:0] <= CH_W'(MAX_CH));
  assign startGo    = wrCtrl && !softRst && busWdata[0] && idle && chanOk;
  assign sampleTake = (state == ST_WAIT) && sampleValid;
  assign lastIdx    = (CONV_W'(1) << actExp) - CONV_W'(1);
  assign lastConv   = (convCnt == lastIdx);
  assign finish     = sampleTake && lastConv && !softRst;
  assign rdData     = busRd && (busAddr == ADDR_W'(OFS_DATA));
  assign istClr     = busWr && (busAddr == ADDR_W'(OFS_IST)) && busWdata[0];

  assign dpCtl.clrAcc    = startGo;
  assign dpCtl.addSample = sampleTake && !softRst;
  assign dpCtl.publish   = finish;
  assign dpCtl.clrData   = softRst;

  assign convStrobe = (state == ST_CONV);
  assign irq        = istBit && ienBit;

  // sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      waitCnt      <= '0;
      convCnt      <= '0;
      muxSel       <= '0;
      actExp       <= '0;
      actFmtBin    <= 1'b0;
      actEvalShort <= 1'b0;
      actRateFast  <= 1'b0;
    end else if (softRst) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      convCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startGo) begin
          state        <= ST_EVAL;
          waitCnt      <= cfgReg[CFG_EVAL] ? EVS_M1 : EVL_M1;
          convCnt      <= '0;
          muxSel       <= cfgReg[CH_W-1:0];
          actExp       <= cfgReg[CFG_EXP_LO +: EXP_W];
          actFmtBin    <= cfgReg[CFG_FMT];
          actEvalShort <= cfgReg[CFG_EVAL];
          actRateFast  <= cfgReg[CFG_RATE];
        end
        ST_EVAL: begin
          if (waitCnt == '0) state <= ST_CONV;
          else waitCnt <= waitCnt - CNT_W'(1);
        end
        ST_CONV: state <= ST_WAIT;
        ST_WAIT: if (sampleTake) begin
          convCnt <= convCnt + CONV_W'(1);
          if (lastConv) begin
            state <= ST_IDLE;
          end else begin
            state   <= ST_GAP;
            waitCnt <= actRateFast ? GPF_M1 : GPS_M1;
          end
        end
        ST_GAP: begin
          if (waitCnt == '0) begin
            state   <= ST_EVAL;
            waitCnt <= actEvalShort ? EVS_M1 : EVL_M1;
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // software-visible state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      ienBit  <= 1'b0;
      istBit  <= 1'b0;
      endFlag <= 1'b0;
    end else begin
      if (busWr && (busAddr == ADDR_W'(OFS_CFG))) cfgReg <= busWdata[CFG_W-1:0] & CFG_MASK;
      if (busWr && (busAddr == ADDR_W'(OFS_IEN))) ienBit <= busWdata[0];

      if (softRst)              endFlag <= 1'b0;
      else if (finish)          endFlag <= 1'b1;
      else if (startGo || rdData) endFlag <= 1'b0;

      if (softRst)                 istBit <= 1'b0;
      else if (finish && ienBit)   istBit <= 1'b1;
      else if (istClr)             istBit <= 1'b0;
    end
  end

  // R4: convert request is a single-cycle pulse
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |=> !convStrobe);
  // R4: a strobe is always preceded by the evaluation phase
  a_r4_strobe_after_eval: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStrobe) |-> $past(state) == ST_EVAL);
  // R3: channel select holds steady while converting
  a_r3_mux_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !startGo) |=> $stable(muxSel));
  // R8: an out-of-range channel never starts a run
  a_r8_bad_channel: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[0] && !softRst && idle && !chanOk) |=> state == ST_IDLE);
  // R7: a start during evaluation does not restart the countdown
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && wrCtrl && !softRst && waitCnt != '0) |=> waitCnt == $past(waitCnt) - CNT_W'(1));
  // R6: accepted start drops the completion flag
  a_r6_flag_clears_on_start: assert property (@(posedge clk) disable iff (!rstN)
    startGo |=> !endFlag);
  // R9: interrupt status only rises at an enabled completion
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(istBit) |-> $past(finish && ienBit));
  // R10: soft reset leaves the block idle with flags clear
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (state == ST_IDLE) && !endFlag && !istBit);
endmodule

// File: rtl/adc_avg_dp.sv
module adc_avg_dp
  import adc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [EXP_W-1:0]  actExp,
  input  logic              actFmtBin,
  output logic [DATA_W-1:0] dataOut
);
  localparam int SUM_W = DATA_W + (1 << EXP_W) - 1;

  logic [SUM_W-1:0]  accReg;
  logic [SUM_W-1:0]  sumNext;
  logic [SUM_W-1:0]  shifted;
  logic [DATA_W-1:0] avgVal;
  logic [DATA_W-1:0] fmtVal;

  assign sumNext = accReg + SUM_W'(sampleData);
  assign shifted = sumNext >> actExp;
  assign avgVal  = shifted[DATA_W-1:0];

  generate
    if (DATA_W > 1) begin : g_fmt
      assign fmtVal = actFmtBin ? avgVal : {~avgVal[DATA_W-1], avgVal[DATA_W-2:0]};
    end else begin : g_fmt1
      assign fmtVal = actFmtBin ? avgVal : ~avgVal;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      dataOut <= '0;
    end else begin
      if (dpCtl.clrAcc)         accReg <= '0;
      else if (dpCtl.addSample) accReg <= sumNext;

      if (dpCtl.clrData)      dataOut <= '0;
      else if (dpCtl.publish) dataOut <= fmtVal;
    end
  end

  // R5: the running sum never wraps
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.addSample |-> sumNext >= accReg);
  // R10: soft reset empties the data word
  a_r10_data_cleared: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.clrData |=> dataOut == '0);
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq
  import adc_avg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int MAX_CH     = 9,
  parameter int EVAL_SHORT = 20,
  parameter int EVAL_LONG  = 40,
  parameter int GAP_FAST   = 4,
  parameter int GAP_SLOW   = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [3:0]        muxSel,
  output logic              convStrobe,
  input  logic              sampleValid,
  input  logic [11:0]       sampleData,
  output logic              irq
);
  dpCtl_t             dpCtl;
  logic [EXP_W-1:0]   actExp;
  logic               actFmtBin;
  logic [CFG_W-1:0]   cfgReg;
  logic               endFlag, ienBit, istBit;
  logic [DATA_W-1:0]  dataOut;

  adc_avg_ctrl #(
    .ADDR_W(ADDR_W), .MAX_CH(MAX_CH),
    .EVAL_SHORT(EVAL_SHORT), .EVAL_LONG(EVAL_LONG),
    .GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .sampleValid(sampleValid),
    .dpCtl(dpCtl), .actExp(actExp), .actFmtBin(actFmtBin),
    .muxSel(muxSel), .convStrobe(convStrobe), .cfgReg(cfgReg),
    .endFlag(endFlag), .ienBit(ienBit), .istBit(istBit), .irq(irq)
  );

  adc_avg_dp uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sampleData(sampleData),
    .actExp(actExp), .actFmtBin(actFmtBin), .dataOut(dataOut)
  );

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_W'(OFS_CFG):   busRdata[CFG_W-1:0]  = cfgReg;
      ADDR_W'(OFS_STAT):  busRdata[DONE_BIT]   = endFlag;
      ADDR_W'(OFS_DATA):  busRdata[DATA_W-1:0] = dataOut;
      ADDR_W'(OFS_IEN):   busRdata[0]          = ienBit;
      ADDR_W'(OFS_IST):   busRdata[0]          = istBit;
      ADDR_W'(OFS_IDENT): busRdata             = IDENT_VALUE;
      default:            busRdata             = '0;
    endcase
  end
endmodule

// File: tb/sim_adc_avg_seq.sv
module sim_adc_avg_seq;
  localparam int ES = 3, EL = 5, GF = 1, GS = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr, busRd;
  logic [5:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic [3:0]  muxSel;
  logic        convStrobe, sampleValid, irq;
  logic [11:0] sampleData;

  always #4 clk = ~clk;

  adc_avg_seq #(.EVAL_SHORT(ES), .EVAL_LONG(EL), .GAP_FAST(GF), .GAP_SLOW(GS)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .muxSel(muxSel),
    .convStrobe(convStrobe), .sampleValid(sampleValid), .sampleData(sampleData), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // converter stand-in
  int lat = 1, pend = 0, sampMode = 0, strobeCount = 0, delivN = 0;
  longint delivSum = 0;
  logic [11:0] constVal = 12'h0;
  logic [15:0] lfsr = 16'hACE1;
  bit spur = 0;

  initial begin sampleValid = 0; sampleData = 0; end

  always @(negedge clk) begin
    sampleValid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        sampleValid = 1'b1;
        if (sampMode == 0) sampleData = constVal;
        else begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          sampleData = lfsr[11:0];
        end
        delivSum += sampleData;
        delivN++;
      end
    end
    if (convStrobe === 1'b1) begin pend = lat; strobeCount++; end
    if (spur) begin sampleValid = 1'b1; sampleData = 12'hFFF; spur = 0; end
  end

  // behavioural reference: 0 idle, 1 settling, 2 strobe, 3 awaiting result, 4 gap
  int mPh = 0, mWait = 0, mCnt = 0, mExp = 0;
  longint mAcc = 0;
  logic [11:0] mData = 0;
  logic [10:0] mCfg = 0;
  logic [3:0]  mMux = 0;
  bit mEnd = 0, mIs = 0, mIe = 0, mBin = 0, mEvS = 0, mFast = 0, done = 0, srst = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mWait = 0; mCnt = 0; mAcc = 0; mData = 0; mCfg = 0; mMux = 0;
      mEnd = 0; mIs = 0; mIe = 0; mExp = 0; mBin = 0; mEvS = 0; mFast = 0;
    end else begin
      done = 0;
      srst = busWr && busAddr == 6'h00 && busWdata[2:1] == 2'b10;
      if (srst) begin
        mPh = 0; mEnd = 0; mIs = 0; mData = 0;
      end else begin
        case (mPh)
          0: if (busWr && busAddr == 6'h00 && busWdata[0] && mCfg[3:0] <= 4'd9) begin
               mPh = 1; mEvS = mCfg[9]; mWait = mEvS ? ES : EL; mMux = mCfg[3:0];
               mExp = int'(mCfg[6:4]); mBin = mCfg[10]; mFast = mCfg[8];
               mAcc = 0; mCnt = 0; mEnd = 0;
             end
          1: if (mWait == 1) mPh = 2; else mWait--;
          2: mPh = 3;
          3: if (sampleValid) begin
               mAcc += sampleData; mCnt++;
               if (mCnt == (1 << mExp)) begin
                 done = 1; mPh = 0; mEnd = 1;
                 mData = 12'((mAcc >> mExp) & 'hFFF);
                 if (!mBin) mData = mData ^ 12'h800;
                 if (mIe) mIs = 1;
               end else begin
                 mPh = 4; mWait = mFast ? GF : GS;
               end
             end
          4: if (mWait == 1) begin mPh = 1; mWait = mEvS ? ES : EL; end else mWait--;
          default: mPh = 0;
        endcase
        if (!done && busRd && busAddr == 6'h0C) mEnd = 0;
        if (!(done && mIe) && busWr && busAddr == 6'h14 && busWdata[0]) mIs = 0;
      end
      if (busWr && busAddr == 6'h04) mCfg = busWdata[10:0] & 11'h77F;
      if (busWr && busAddr == 6'h10) mIe = busWdata[0];
    end
  end

  always @(negedge clk) begin
    #1;
    if (rstN === 1'b1 && !finished) begin
      check("R4", "convStrobe vs model", {31'b0, convStrobe}, {31'b0, mPh == 2});
      check("R3", "muxSel vs model", {28'b0, muxSel}, {28'b0, mMux});
      check("R9", "irq vs model", {31'b0, irq}, {31'b0, mIs && mIe});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #2 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (mPh != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearStats();
    strobeCount = 0; delivN = 0; delivSum = 0;
  endtask

  function automatic logic [31:0] avgOf(input longint s, input int n, input bit bin);
    logic [11:0] v;
    v = 12'((s >> n) & 'hFFF);
    if (!bin) v = v ^ 12'h800;
    return {20'b0, v};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] savedData;
    int sc;
    busWr = 0; busRd = 0; busAddr = 0; busWdata = 0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    rd(6'h08, rv); check("R2", "status after reset", rv, 32'h0);
    rd(6'h0C, rv); check("R2", "data after reset", rv, 32'h0);
    rd(6'h04, rv); check("R2", "config after reset", rv, 32'h0);
    rd(6'h14, rv); check("R2", "irq status after reset", rv, 32'h0);
    check("R2", "irq/strobe after reset", {30'b0, irq, convStrobe}, 32'h0);

    // identity and reserved words
    rd(6'h20, rv); check("R1", "identity word", rv, 32'h8000_0008);
    rd(6'h18, rv); check("R1", "reserved 0x18", rv, 32'h0);
    rd(6'h1C, rv); check("R1", "reserved 0x1C", rv, 32'h0);

    // single conversion, binary, interrupt enabled
    wr(6'h10, 32'h1);
    sampMode = 0; constVal = 12'hABC; lat = 1; clearStats();
    wr(6'h04, 32'h703);
    wr(6'h00, 32'h1);
    rd(6'h00, rv); check("R3", "start bit self-clears", rv & 32'h1, 32'h0);
    waitIdle();
    check("R4", "strobes for n=0", strobeCount, 1);
    rd(6'h08, rv); check("R6", "done flag set", rv, 32'h4);
    check("R9", "irq raised", {31'b0, irq}, 32'h1);
    rd(6'h0C, rv); check("R5", "binary single result", rv, 32'hABC);
    rd(6'h08, rv); check("R6", "done cleared by data read", rv, 32'h0);
    wr(6'h14, 32'h1);
    @(negedge clk); #1 check("R9", "irq cleared by w1c", {31'b0, irq}, 32'h0);

    // eight conversions, slow rate, long evaluation, two's complement
    constVal = 12'h123; lat = 2; clearStats();
    wr(6'h04, 32'h039);
    wr(6'h00, 32'h1);
    waitIdle();
    check("R4", "strobes for n=3", strobeCount, 8);
    rd(6'h0C, rv); check("R5", "two's complement average", rv, 32'h923);

    // 128 pseudo-random conversions
    sampMode = 1; lat = 3; clearStats();
    wr(6'h04, 32'h775);
    wr(6'h00, 32'h1);
    waitIdle();
    check("R4", "deliveries for n=7", delivN, 128);
    rd(6'h0C, rv); check("R5", "average of 128 samples", rv, avgOf(delivSum, 7, 1));

    // start while busy, config rewritten mid-run
    clearStats();
    wr(6'h04, 32'h522);
    wr(6'h00, 32'h1);
    wr(6'h04, 32'h571);
    wr(6'h00, 32'h1);
    waitIdle();
    check("R7", "no extra strobes", strobeCount, 4);
    rd(6'h0C, rv); check("R7", "result of original run", rv, avgOf(delivSum, 2, 1));
    savedData = rv;
    rd(6'h04, rv); check("R7", "config write kept", rv, 32'h571);

    // out-of-range channel
    clearStats();
    wr(6'h04, 32'h70C);
    wr(6'h00, 32'h1);
    repeat (15) @(negedge clk);
    check("R8", "no strobes for channel 12", strobeCount, 0);
    rd(6'h0C, rv); check("R8", "data untouched", rv, savedData);

    // soft reset mid-sequence
    wr(6'h04, 32'h745);
    wr(6'h00, 32'h1);
    repeat (12) @(negedge clk);
    wr(6'h00, 32'h4);
    sc = strobeCount;
    repeat (30) @(negedge clk);
    check("R10", "no strobes after abort", strobeCount, sc);
    rd(6'h08, rv); check("R10", "status cleared", rv, 32'h0);
    rd(6'h0C, rv); check("R10", "data cleared", rv, 32'h0);
    rd(6'h14, rv); check("R10", "irq status cleared", rv, 32'h0);
    rd(6'h04, rv); check("R10", "config kept", rv, 32'h745);
    rd(6'h10, rv); check("R10", "enable kept", rv, 32'h1);

    // stray valid pulses in idle and during evaluation
    sampMode = 0; constVal = 12'h010; lat = 1; clearStats();
    wr(6'h04, 32'h510);
    spur = 1;
    repeat (3) @(negedge clk);
    wr(6'h00, 32'h1);
    spur = 1;
    waitIdle();
    check("R11", "only real results counted", delivN, 2);
    rd(6'h0C, rv); check("R11", "stray valid ignored", rv, 32'h010);

    // completion with interrupt disabled
    wr(6'h14, 32'h1);
    wr(6'h10, 32'h0);
    constVal = 12'h800; clearStats();
    wr(6'h04, 32'h307);
    wr(6'h00, 32'h1);
    waitIdle();
    rd(6'h14, rv); check("R9", "no irq status when disabled", rv, 32'h0);
    check("R9", "irq low when disabled", {31'b0, irq}, 32'h0);
    rd(6'h08, rv); check("R6", "done flag without irq", rv, 32'h4);
    rd(6'h0C, rv); check("R5", "two's complement midscale", rv, 32'h000);

    finished = 1;
    summary();
    $finish;
  end
endmodule